// File: doc/BRIEF.md
# Scaled Integer-to-Float Normalizer

This block executes a normalize instruction. It takes a 16-bit two's-complement integer from the A register and a signed 8-bit scale that is carried in the low byte of the instruction word. It returns a normalized floating-point value for the accumulator registers T, A and D. The result equals the integer multiplied by two to the power of (scale − 16), so a scale of +16 gives a plain integer-to-float conversion. A larger scale gives a proportionally larger result.

A mode input selects between two result formats. In the wide (48-bit) format the block writes T, A and D. In the narrow (32-bit) format it writes only A and D and leaves T alone. Software can use this difference to tell which variant it runs on. It presets T to zero, converts the integer 1 with a scale of 16, and then tests whether T has changed.

The sequencer raises a one-cycle start together with the instruction word and the A operand. One clock later the block returns a done strobe, per-register write enables and the three result words. The leading-one search and the alignment shift complete in a single cycle.

Top module: `scaled_int_normalizer`

## Requirements
- R1: A start is accepted only when instruction bits [15:8] equal 8'hD3 (the upper byte of octal 151400). If start is low or the upper byte differs, done and all write enables (t_we, a_we, d_we) are low in the next cycle.
- R2: After an accepted start, done, a_we and d_we are high for exactly one cycle, in the cycle after start. After reset, done and all write enables are low.
- R3: In wide mode (mode48=1), t_out[15] is the sign and t_out[14:0] is the exponent 16384 + scale − 16 + (index of leading one of |A| + 1). {a_out,d_out} is the 32-bit magnitude mantissa, left-justified, with bit 31 set for non-zero input.
- R4: Word 16'hD310 (octal 151420, scale +16) yields a value numerically equal to the integer. For A=1 the result is T=16'h4001, A=16'h8000, D=0.
- R5: In wide mode d_out is always zero.
- R6: Negative inputs are converted to sign and magnitude. −32768 gives magnitude 32768 with the sign set: T=16'hC010, A=16'h8000 at scale 16.
- R7: An input of zero gives all-zero result words for any scale, in both modes.
- R8: In narrow mode (mode48=0), t_we stays low and t_out is zero. a_out[15] is the sign, a_out[14:7] is the exponent 128 + scale − 16 + (leading-one index + 1), and {a_out[6:0], d_out} holds the 23 mantissa bits below the implied leading one.
- R9: In narrow mode, an exponent below zero flushes A and D to zero. An exponent of 1 is still encoded normally.
- R10: The scale is signed over its full range −128…+127 (low byte 8'h80 to 8'h7F), and it adds directly to the exponent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request with a valid instruction and operand |
| mode48 | input | 1 | 1 selects the 48-bit format, 0 the 32-bit format |
| instr | input | 16 | Instruction word: opcode in [15:8], signed scale in [7:0] |
| a_in | input | 16 | Two's-complement integer operand |
| done | output | 1 | One-cycle completion strobe |
| t_we | output | 1 | Write enable for T |
| a_we | output | 1 | Write enable for A |
| d_we | output | 1 | Write enable for D |
| t_out | output | 16 | Result word for T |
| a_out | output | 16 | Result word for A |
| d_out | output | 16 | Result word for D |

## Verification
The conversion is exercised with the integers 1, 3, 5 and 0x7FFF, which put the leading one at the bottom, near the bottom and at the top of the positive range, and so test both the encoder index and the shift distance. The inputs −1, −5 and −32768 separate a correct magnitude conversion from a plain bit copy. The input −32768 is the one case where the magnitude has no positive counterpart. Scales of 0, 16, +127 and −128 show that the scale is sign-extended and added rather than treated as unsigned. In narrow mode, exponents of −15 and +1 sit on either side of the flush boundary, and an exponent of 255 sits at the top of the field. The T-preservation test from software, with an opcode mismatch and an idle start, shows that writes happen only on an accepted instruction.

// File: rtl/norm_pkg.sv
package norm_pkg;

  localparam int unsigned WORD_W     = 16;
  localparam int unsigned SCALE_W    = 8;
  localparam int unsigned MANT_W     = 32;
  localparam int unsigned EXP48_W    = 15;
  localparam int unsigned EXP32_W    = 8;
  localparam int unsigned BIAS48     = 16384;
  localparam int unsigned BIAS32     = 128;
  localparam int unsigned EXP_CALC_W = 18;
  localparam logic [7:0]  OPC_NORM   = 8'hD3;

  typedef struct packed {
    logic [WORD_W-1:0] t;
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] d;
  } acc_triple_t;

endpackage

// File: rtl/norm_lead_one.sv
module norm_lead_one #(
  parameter int unsigned W     = 16,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             nz
);

  // Scan upward; the highest set bit wins by being assigned last.
  always_comb begin
    idx = '0;
    nz  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        idx = IDX_W'(i);
        nz  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/norm_shifter.sv
module norm_shifter #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32,
  localparam int unsigned SH_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SH_W-1:0]  sh,
  output logic [OUT_W-1:0] dout
);

  localparam int unsigned PAD_W = OUT_W - IN_W;

  logic [OUT_W-1:0] stage [SH_W+1];

  assign stage[0] = {din, {PAD_W{1'b0}}};

  // Logarithmic shifter: stage g moves by 2^g when sh[g] is set.
  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    assign stage[g+1] = sh[g] ? (stage[g] << (1 << g)) : stage[g];
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/norm_pack.sv
module norm_pack
  import norm_pkg::*;
#(
  parameter int unsigned INT_W   = WORD_W,
  parameter int unsigned SC_W    = SCALE_W,
  parameter int unsigned M_W     = MANT_W,
  parameter int unsigned E48_W   = EXP48_W,
  parameter int unsigned E32_W   = EXP32_W,
  parameter int unsigned B48     = BIAS48,
  parameter int unsigned B32     = BIAS32,
  parameter int unsigned CALC_W  = EXP_CALC_W,
  localparam int unsigned IDX_W  = $clog2(INT_W)
) (
  input  logic              sign,
  input  logic              nz,
  input  logic [IDX_W-1:0]  lead_idx,
  input  logic [M_W-1:0]    mant,
  input  logic [SC_W-1:0]   scale,
  input  logic              mode48,
  output acc_triple_t       res
);

  localparam int unsigned FRAC_A_W = INT_W - 1 - E32_W;
  localparam int unsigned FRAC_TOP = M_W - 2;
  localparam int unsigned D32_TOP  = FRAC_TOP - FRAC_A_W;
  localparam logic signed [CALC_W-1:0] OFF48   = CALC_W'(B48 - INT_W + 1);
  localparam logic signed [CALC_W-1:0] OFF32   = CALC_W'(B32 - INT_W + 1);
  localparam logic signed [CALC_W-1:0] E32_MAX = CALC_W'((1 << E32_W) - 1);

  logic signed [CALC_W-1:0] scale_ext;
  logic signed [CALC_W-1:0] idx_ext;
  logic        [E48_W-1:0]  exp48;
  logic signed [CALC_W-1:0] exp32_full;
  logic                     under32;
  logic                     over32;

  assign scale_ext  = CALC_W'(signed'(scale));
  assign idx_ext    = CALC_W'(lead_idx);
  assign exp48      = E48_W'(OFF48 + scale_ext + idx_ext);
  assign exp32_full = OFF32 + scale_ext + idx_ext;
  assign under32    = exp32_full < 0;
  assign over32     = exp32_full > E32_MAX;

  always_comb begin
    res = '0;
    if (nz) begin
      if (mode48) begin
        res.t = {sign, exp48};
        res.a = mant[M_W-1 -: INT_W];
        res.d = mant[M_W-INT_W-1 -: INT_W];
      end else if (over32) begin
        res.a = {sign, {E32_W{1'b1}}, {FRAC_A_W{1'b1}}};
        res.d = '1;
      end else if (!under32) begin
        res.a = {sign, exp32_full[E32_W-1:0], mant[FRAC_TOP -: FRAC_A_W]};
        res.d = mant[D32_TOP -: INT_W];
      end
    end
  end

endmodule

// File: rtl/scaled_int_normalizer.sv
module scaled_int_normalizer
  import norm_pkg::*;
#(
  parameter int unsigned INT_W  = WORD_W,
  parameter int unsigned SC_W   = SCALE_W,
  parameter int unsigned M_W    = MANT_W,
  parameter logic [INT_W-SC_W-1:0] OPCODE = OPC_NORM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode48,
  input  logic [INT_W-1:0] instr,
  input  logic [INT_W-1:0] a_in,
  output logic             done,
  output logic             t_we,
  output logic             a_we,
  output logic             d_we,
  output logic [INT_W-1:0] t_out,
  output logic [INT_W-1:0] a_out,
  output logic [INT_W-1:0] d_out
);

  localparam int unsigned IDX_W = $clog2(INT_W);
  localparam int unsigned OPC_W = INT_W - SC_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // Decode and operand conditioning.
  logic             accept;
  logic             sign;
  logic [INT_W-1:0] mag;
  logic [SC_W-1:0]  scale;

  assign accept = start && (instr[INT_W-1 -: OPC_W] == OPCODE);
  assign scale  = instr[SC_W-1:0];
  assign sign   = a_in[INT_W-1];
  assign mag    = sign ? (~a_in + 1'b1) : a_in;

  // Normalization datapath.
  logic [IDX_W-1:0] lead_idx;
  logic             nz;
  logic [IDX_W-1:0] shamt;
  logic [M_W-1:0]   mant;
  acc_triple_t      res;

  norm_lead_one #(.W(INT_W)) i_lead (
    .vec (mag),
    .idx (lead_idx),
    .nz  (nz)
  );

  assign shamt = IDX_W'(INT_W - 1) - lead_idx;

  norm_shifter #(.IN_W(INT_W), .OUT_W(M_W)) i_shift (
    .din  (mag),
    .sh   (shamt),
    .dout (mant)
  );

  norm_pack #(.INT_W(INT_W), .SC_W(SC_W), .M_W(M_W)) i_pack (
    .sign     (sign && nz),
    .nz       (nz),
    .lead_idx (lead_idx),
    .mant     (mant),
    .scale    (scale),
    .mode48   (mode48),
    .res      (res)
  );

  // Next state.
  logic        done_d, t_we_d, a_we_d, d_we_d;
  logic        data_en;
  acc_triple_t data_q;

  always_comb begin
    done_d  = accept;
    a_we_d  = accept;
    d_we_d  = accept;
    t_we_d  = accept && mode48;
    data_en = accept;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done <= 1'b0;
      t_we <= 1'b0;
      a_we <= 1'b0;
      d_we <= 1'b0;
    end else begin
      done <= done_d;
      t_we <= t_we_d;
      a_we <= a_we_d;
      d_we <= d_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     data_q <= '0;
    else if (data_en) data_q <= res;
  end

  assign t_out = data_q.t;
  assign a_out = data_q.a;
  assign d_out = data_q.d;

  // Assertions.
  p_miss_quiet_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !accept |=> (!done && !t_we && !a_we && !d_we));

  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    accept |=> (done && a_we && d_we));

  p_t_written_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (accept && mode48) |=> t_we);

  p_norm_msb_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && t_we && (a_out != '0)) |-> a_out[INT_W-1]);

  p_d_clear_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && t_we) |-> (d_out == '0));

  p_zero_in_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (accept && (a_in == '0)) |=> (t_out == '0 && a_out == '0 && d_out == '0));

  p_t_kept_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (accept && !mode48) |=> (!t_we && t_out == '0));

endmodule

// File: tb/test_scaled_int_normalizer.sv
module test_scaled_int_normalizer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        mode48;
  logic [15:0] instr;
  logic [15:0] a_in;
  logic        done, t_we, a_we, d_we;
  logic [15:0] t_out, a_out, d_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  scaled_int_normalizer i_scaled_int_normalizer (
    .clk(clk), .rst_n(rst_n), .start(start), .mode48(mode48),
    .instr(instr), .a_in(a_in), .done(done), .t_we(t_we),
    .a_we(a_we), .d_we(d_we), .t_out(t_out), .a_out(a_out), .d_out(d_out)
  );

  // {req, mode48, instr, a_in, t_we, t, a, d}
  localparam int NV = 16;
  localparam logic [85:0] VEC [NV] = '{
    {4'd4,  1'b1, 16'hD310, 16'h0001, 1'b1, 16'h4001, 16'h8000, 16'h0000}, // R4
    {4'd3,  1'b1, 16'hD310, 16'h0005, 1'b1, 16'h4003, 16'hA000, 16'h0000}, // R3
    {4'd6,  1'b1, 16'hD310, 16'hFFFF, 1'b1, 16'hC001, 16'h8000, 16'h0000}, // R6
    {4'd6,  1'b1, 16'hD310, 16'h8000, 1'b1, 16'hC010, 16'h8000, 16'h0000}, // R6
    {4'd7,  1'b1, 16'hD305, 16'h0000, 1'b1, 16'h0000, 16'h0000, 16'h0000}, // R7
    {4'd5,  1'b1, 16'hD310, 16'h7FFF, 1'b1, 16'h400F, 16'hFFFE, 16'h0000}, // R5
    {4'd10, 1'b1, 16'hD37F, 16'h0001, 1'b1, 16'h4070, 16'h8000, 16'h0000}, // R10
    {4'd10, 1'b1, 16'hD380, 16'h0001, 1'b1, 16'h3F71, 16'h8000, 16'h0000}, // R10
    {4'd3,  1'b1, 16'hD300, 16'h0003, 1'b1, 16'h3FF2, 16'hC000, 16'h0000}, // R3
    {4'd8,  1'b0, 16'hD310, 16'h0001, 1'b0, 16'h0000, 16'h4080, 16'h0000}, // R8
    {4'd8,  1'b0, 16'hD310, 16'hFFFB, 1'b0, 16'h0000, 16'hC1A0, 16'h0000}, // R8
    {4'd8,  1'b0, 16'hD310, 16'h7FFF, 1'b0, 16'h0000, 16'h47FF, 16'hFE00}, // R8
    {4'd9,  1'b0, 16'hD380, 16'h0001, 1'b0, 16'h0000, 16'h0000, 16'h0000}, // R9
    {4'd9,  1'b0, 16'hD38F, 16'h0002, 1'b0, 16'h0000, 16'h0080, 16'h0000}, // R9
    {4'd8,  1'b0, 16'hD37F, 16'h8000, 1'b0, 16'h0000, 16'hFF80, 16'h0000}, // R8
    {4'd7,  1'b0, 16'hD37F, 16'h0000, 1'b0, 16'h0000, 16'h0000, 16'h0000}  // R7
  };

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic m, input logic [15:0] w,
                       input logic [15:0] a, input logic s);
    @(negedge clk);
    start  = s;
    mode48 = m;
    instr  = w;
    a_in   = a;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode48 = 1'b1; instr = '0; a_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R2: reset state
    check(!done && !t_we && !a_we && !d_we && t_out == 0 && a_out == 0 && d_out == 0,
          "R2 reset state", {done, t_we, a_we, d_we, t_out, a_out, d_out}, 64'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [85:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[85:82], i);
      issue(v[81], v[80:65], v[64:49], 1'b1);
      check(done && a_we && d_we && (t_we == v[48]), {tag, " strobes"},
            {done, t_we, a_we, d_we}, {1'b1, v[48], 2'b11});
      check({t_out, a_out, d_out} == v[47:0], {tag, " result"},
            {t_out, a_out, d_out}, v[47:0]);
    end

    // R2: done is a single-cycle strobe
    issue(1'b1, 16'hD310, 16'h0001, 1'b1);
    @(negedge clk);
    check(!done && !a_we && !d_we && !t_we, "R2 strobe drops",
          {done, t_we, a_we, d_we}, 64'h0);

    // R1: opcode mismatch is ignored
    issue(1'b1, 16'hD210, 16'h0007, 1'b1);
    check(!done && !t_we && !a_we && !d_we, "R1 opcode miss",
          {done, t_we, a_we, d_we}, 64'h0);
    check(t_out == 16'h4001 && a_out == 16'h8000, "R1 result held",
          {t_out, a_out}, {16'h4001, 16'h8000});

    // R1: matching word without start is ignored
    issue(1'b1, 16'hD310, 16'h0007, 1'b0);
    check(!done && !a_we, "R1 no start", {done, a_we}, 64'h0);

    // R8: variant detection with A=1, scale 16
    issue(1'b1, 16'hD310, 16'h0001, 1'b1);
    check(t_we && t_out != 0, "R8 wide writes nonzero T", {t_we, t_out}, {1'b1, 16'h4001});
    issue(1'b0, 16'hD310, 16'h0001, 1'b1);
    check(!t_we && a_we, "R8 narrow leaves T", {t_we, a_we}, {1'b0, 1'b1});

    // R9: exponent -1 flushes in narrow mode
    issue(1'b0, 16'hD38E, 16'h0001, 1'b1);
    check(a_out == 0 && d_out == 0 && a_we, "R9 flush at -1",
          {a_out, d_out}, 64'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule